// File: doc/BRIEF.md
# PCM Feedback Tone Inserter

This block sits on the receive side of an 8 kHz framed serial voice link carrying two 8-bit voice channels per frame. On each frame boundary it decides what octet goes out on voice channel one: either the octet received from the line, or one of two fixed companded PCM codes that together form a 500 Hz square-wave tone. The tone gives the user audible feedback, for example on key presses. Voice channel two is always forwarded untouched.

The tone is produced directly in the companded domain. No linear samples and no encoder are involved. A frame counter walks through one tone period of 16 frames. The first 8 frames of the period emit the positive code and the last 8 emit the negative code. A law-select input picks which code pair is used: the mu-law pair or the A-law pair. The enable and the law select only count at a frame boundary, so one forwarded octet is never part tone and part line data. Each new enable restarts the tone at the start of its positive half.

Top module: `tone_b1_inserter`

## Requirements
- R1: While rst_n is low, and on the first cycle after a reset edge, both ch1_out and ch2_out read 8'h00.
- R2: ch1_out and ch2_out change only on the clock edge that samples frame_stb high; at every other edge they hold their value.
- R3: When tone_en is 0 at a frame strobe, ch1_out takes the ch1_in value sampled at that strobe.
- R4: At every frame strobe, ch2_out takes the ch2_in value sampled at that strobe, whatever tone_en and law_mu are.
- R5: When tone_en is 1 at a strobe, ch1_out is a tone code. With law_mu=1 the code is the mu-law pair: positive 8'hA3, negative 8'h23. With law_mu=0 it is the A-law pair: positive 8'hB4, negative 8'h34. These are the default parameter values.
- R6: While tone_en stays 1 across consecutive strobes, the code runs in a 16-frame cycle: 8 frames positive, then 8 frames negative, then the cycle repeats.
- R7: The first strobe with tone_en=1 after a strobe with tone_en=0, or after reset, emits the positive code and starts a new 16-frame cycle.
- R8: Changes on ch1_in, ch2_in, tone_en and law_mu between strobes have no effect on the outputs.
- R9: Changing law_mu while the tone runs switches the code pair at the next strobe without disturbing the tone phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_stb | input | 1 | One-cycle pulse marking a frame boundary |
| tone_en | input | 1 | 1 = replace channel one with the tone |
| law_mu | input | 1 | 1 = mu-law codes, 0 = A-law codes |
| ch1_in | input | 8 | Received voice channel one octet |
| ch2_in | input | 8 | Received voice channel two octet |
| ch1_out | output | 8 | Forwarded voice channel one octet |
| ch2_out | output | 8 | Forwarded voice channel two octet |

## Verification
Every result is due exactly one clock after the edge that samples frame_stb high. The bench drives frame_stb and the frame inputs on a falling edge, drops the strobe on the next falling edge, and reads the outputs there, once the single register stage has taken them. Between strobes it scrambles every input and reads the outputs again. This confirms they held their value across the idle edges. The expected tone code comes from a phase counter kept in the bench. It advances once per enabled strobe and resets on each new enable.

// File: rtl/tone_pkg.sv
package tone_pkg;

  typedef enum logic {
    LAW_A  = 1'b0,
    LAW_MU = 1'b1
  } law_t;

  // Frames in one full tone period.
  function automatic int unsigned frames_per_period(int unsigned frame_hz,
                                                    int unsigned tone_hz);
    return frame_hz / tone_hz;
  endfunction

  // True in the second (negative) half of the period.
  function automatic logic in_neg_half(int unsigned phase, int unsigned period);
    return phase >= (period / 2);
  endfunction

  // Pick one of four fixed codes from law and half.
  function automatic logic [7:0] pick_code(law_t law, logic neg,
                                           logic [7:0] mu_p, logic [7:0] mu_n,
                                           logic [7:0] a_p,  logic [7:0] a_n);
    if (law == LAW_MU) return neg ? mu_n : mu_p;
    return neg ? a_n : a_p;
  endfunction

endpackage

// File: rtl/tone_frame_sampler.sv
module tone_frame_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_stb,
  input  logic tone_en,
  output logic fire,
  output logic start_evt
);
  logic en_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         en_q <= 1'b0;
    else if (frame_stb) en_q <= tone_en;
  end

  assign fire      = frame_stb & tone_en;
  assign start_evt = fire & ~en_q;
endmodule

// File: rtl/tone_phase_gen.sv
module tone_phase_gen #(
  parameter int unsigned PERIOD = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_stb,
  input  logic fire,
  input  logic start_evt,
  output logic neg_half
);
  import tone_pkg::*;
  localparam int unsigned PW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [PW-1:0] LAST = PW'(PERIOD - 1);

  logic [PW-1:0] cnt_q;
  logic [PW-1:0] phase_now;

  assign phase_now = start_evt ? '0 : cnt_q;
  assign neg_half  = in_neg_half(int'(phase_now), PERIOD);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else if (frame_stb) begin
      if (!fire)                  cnt_q <= '0;
      else if (phase_now == LAST) cnt_q <= '0;
      else                        cnt_q <= phase_now + 1'b1;
    end
  end
endmodule

// File: rtl/tone_code_sel.sv
module tone_code_sel #(
  parameter logic [7:0] MU_POS = 8'hA3,
  parameter logic [7:0] MU_NEG = 8'h23,
  parameter logic [7:0] A_POS  = 8'hB4,
  parameter logic [7:0] A_NEG  = 8'h34
) (
  input  logic       law_mu,
  input  logic       neg_half,
  output logic [7:0] code
);
  import tone_pkg::*;
  assign code = pick_code(law_t'(law_mu), neg_half, MU_POS, MU_NEG, A_POS, A_NEG);
endmodule

// File: rtl/tone_b1_inserter.sv
module tone_b1_inserter #(
  parameter int unsigned FRAME_HZ = 8000,
  parameter int unsigned TONE_HZ  = 500,
  parameter logic [7:0]  MU_POS   = 8'hA3,
  parameter logic [7:0]  MU_NEG   = 8'h23,
  parameter logic [7:0]  A_POS    = 8'hB4,
  parameter logic [7:0]  A_NEG    = 8'h34
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_stb,
  input  logic       tone_en,
  input  logic       law_mu,
  input  logic [7:0] ch1_in,
  input  logic [7:0] ch2_in,
  output logic [7:0] ch1_out,
  output logic [7:0] ch2_out
);
  import tone_pkg::*;
  localparam int unsigned PERIOD = frames_per_period(FRAME_HZ, TONE_HZ);

  logic       fire;
  logic       start_evt;
  logic       neg_half;
  logic [7:0] tone_code;

  tone_frame_sampler u_smp (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .tone_en(tone_en),
    .fire(fire), .start_evt(start_evt)
  );

  tone_phase_gen #(.PERIOD(PERIOD)) u_phase (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .fire(fire),
    .start_evt(start_evt), .neg_half(neg_half)
  );

  tone_code_sel #(.MU_POS(MU_POS), .MU_NEG(MU_NEG), .A_POS(A_POS), .A_NEG(A_NEG)) u_code (
    .law_mu(law_mu), .neg_half(neg_half), .code(tone_code)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ch1_out <= '0;
      ch2_out <= '0;
    end else if (frame_stb) begin
      ch1_out <= fire ? tone_code : ch1_in;
      ch2_out <= ch2_in;
    end
  end
endmodule

// File: rtl/tone_b1_checker.sv
module tone_b1_checker #(
  parameter logic [7:0] MU_POS = 8'hA3,
  parameter logic [7:0] MU_NEG = 8'h23,
  parameter logic [7:0] A_POS  = 8'hB4,
  parameter logic [7:0] A_NEG  = 8'h34
) (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_stb,
  input logic       tone_en,
  input logic       law_mu,
  input logic [7:0] ch1_in,
  input logic [7:0] ch2_in,
  input logic [7:0] ch1_out,
  input logic [7:0] ch2_out,
  input logic       start_evt
);
  assert_reset_zero_R1: assert property (@(posedge clk)
    !rst_n |=> (ch1_out == 8'h00 && ch2_out == 8'h00));

  assert_hold_between_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_stb |=> ($stable(ch1_out) && $stable(ch2_out)));

  assert_pass_ch1_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stb && !tone_en) |=> ch1_out == $past(ch1_in));

  assert_pass_ch2_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb |=> ch2_out == $past(ch2_in));

  assert_mu_codes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stb && tone_en && law_mu) |=> (ch1_out == MU_POS || ch1_out == MU_NEG));

  assert_a_codes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stb && tone_en && !law_mu) |=> (ch1_out == A_POS || ch1_out == A_NEG));

  assert_restart_pos_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (ch1_out == ($past(law_mu) ? MU_POS : A_POS)));

  assert_start_needs_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |-> (frame_stb && tone_en));
endmodule

bind tone_b1_inserter tone_b1_checker #(
  .MU_POS(MU_POS), .MU_NEG(MU_NEG), .A_POS(A_POS), .A_NEG(A_NEG)
) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .tone_en(tone_en),
  .law_mu(law_mu), .ch1_in(ch1_in), .ch2_in(ch2_in), .ch1_out(ch1_out),
  .ch2_out(ch2_out), .start_evt(start_evt)
);

// File: tb/tone_b1_inserter_tb.sv
module tone_b1_inserter_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_stb = 1'b0;
  logic       tone_en = 1'b0;
  logic       law_mu = 1'b0;
  logic [7:0] ch1_in = '0;
  logic [7:0] ch2_in = '0;
  logic [7:0] ch1_out, ch2_out;

  int n_chk = 0;
  int n_bad = 0;
  int ph = 0;
  bit prev_en = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tone_b1_inserter u_dut (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .tone_en(tone_en),
    .law_mu(law_mu), .ch1_in(ch1_in), .ch2_in(ch2_in),
    .ch1_out(ch1_out), .ch2_out(ch2_out)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] tone_exp(bit mu, int p);
    bit neg = (p % 16) >= 8;
    if (mu) return neg ? 8'h23 : 8'hA3;
    return neg ? 8'h34 : 8'hB4;
  endfunction

  // One frame: strobe with given inputs, check, scramble inputs, recheck.
  task automatic frame(bit en, bit mu, logic [7:0] a, logic [7:0] b, string req);
    logic [7:0] e1;
    @(negedge clk);
    tone_en = en; law_mu = mu; ch1_in = a; ch2_in = b; frame_stb = 1'b1;
    if (en) begin
      if (!prev_en) ph = 0;
      e1 = tone_exp(mu, ph);
      ph = (ph + 1) % 16;
    end else begin
      e1 = a;
      ph = 0;
    end
    prev_en = en;
    @(negedge clk);
    frame_stb = 1'b0;
    chk(req, ch1_out, e1);
    chk("R4", ch2_out, b);
    ch1_in = ~a; ch2_in = ~b; tone_en = ~en; law_mu = ~mu;
    @(negedge clk); @(negedge clk);
    chk("R8 ch1", ch1_out, e1);
    chk("R2 ch2", ch2_out, b);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ch1", ch1_out, 8'h00);
    chk("R1 ch2", ch2_out, 8'h00);
    rst_n = 1'b1;
    // R3/R4: pass-through sweep of every octet value
    for (int v = 0; v < 256; v++) frame(1'b0, v[0], 8'(v), 8'(255 - v), "R3");
    // R5/R6: mu-law tone over several periods
    for (int f = 0; f < 40; f++) frame(1'b1, 1'b1, 8'(f), 8'(f * 3), "R6 mu");
    // R9: law change mid-tone keeps phase
    for (int f = 0; f < 20; f++) frame(1'b1, f[1], 8'h55, 8'(f), "R9");
    // R7: disable, then restart begins at positive half
    frame(1'b0, 1'b0, 8'h7E, 8'h11, "R3 gap");
    frame(1'b1, 1'b0, 8'h00, 8'h22, "R7 A");
    for (int f = 0; f < 5; f++) frame(1'b1, 1'b0, 8'hFF, 8'h33, "R6 A");
    frame(1'b0, 1'b1, 8'h81, 8'h44, "R3 gap");
    frame(1'b1, 1'b1, 8'h00, 8'h55, "R7 mu");
    // R5: A-law tone over several periods
    for (int f = 0; f < 36; f++) frame(1'b1, 1'b0, 8'(f), 8'(f), "R5 A");
    // R1: reset mid-tone clears outputs and phase
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R1 mid ch1", ch1_out, 8'h00);
    chk("R1 mid ch2", ch2_out, 8'h00);
    rst_n = 1'b1; prev_en = 1'b0;
    frame(1'b1, 1'b1, 8'h12, 8'h34, "R7 after reset");
    for (int f = 0; f < 10; f++) frame(1'b1, 1'b1, 8'h12, 8'h34, "R6 after reset");
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule